// File: doc/BRIEF.md
# Numerically Controlled Oscillator with Phase Readout Select

This block produces a pair of 16-bit two's-complement sine and cosine samples, one pair per clock, from a 32-bit phase accumulator. A host writes the 32-bit tuning word over a small memory-style bus as two 16-bit halves. The high half commits the whole word, so the accumulator never runs on a half-updated value. The top ten phase bits drive a quarter-wave table through quadrant folding. The table and its sign handling form a fixed pipeline.

A synchronous select input steers a register at the very end of the datapath. On each clock edge it loads either the sine/cosine pair or the raw accumulator word, delayed to the same depth. Run at twice the wanted sample rate, the block gives the host spare cycles between samples to read the running phase, and the sinusoid is never interrupted. The host shares the block's clock.

Top module: `nco_phase_tap`

## Requirements
- R1: While `rst_n` is low, `cos_out` and `sin_out` read zero, and the accumulator, the staged low half and the committed tuning word are all zero.
- R2: A write happens on a rising edge with `cs_n` low and `wr_en` high. Address 0 stages the low half. Address 1 commits the tuning word `{wdata, staged low half}` on that edge.
- R3: A write to address 0 alone leaves the tuning word that the accumulator adds unchanged.
- R4: Edges with `cs_n` high, with `wr_en` low, or with an address from 2 to 7 change neither the staged low half nor the tuning word.
- R5: On every edge out of reset, the accumulator adds the committed tuning word, modulo 2^32.
- R6: When `test_sel` is high at an edge, that edge loads `cos_out` with accumulator bits 31:16 and `sin_out` with bits 15:0. The accumulator value used is the one present three edges earlier.
- R7: When `test_sel` is low at an edge, the outputs take the sinusoid of that same three-edge-old accumulator value. Let p be its bits 31:22 and a = (2p+1)·π/1024. Then `sin_out` = sign(sin a)·round(32767·|sin a|) and `cos_out` = sign(cos a)·round(32767·|cos a|), both in two's complement.
- R8: `test_sel` is sampled on each edge on its own terms, so alternating it every cycle alternates phase words and sinusoid samples with no lost or repeated sample.
- R9: After a commit edge E, the outputs first reflect the new word after edge E+4. This holds in both output modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the host |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_en | input | 1 | Write strobe, active high |
| addr | input | 3 | Register address (0 low half, 1 high half and commit) |
| wdata | input | 16 | Write data |
| test_sel | input | 1 | High selects phase readout instead of the sinusoid |
| cos_out | output | 16 | Cosine sample or phase bits 31:16 |
| sin_out | output | 16 | Sine sample or phase bits 15:0 |

## Verification
A tuning-word commit and a change of `test_sel` can land on the same edges. The new word then ripples through the pipeline while the output mux switches source. The bench commits a word with the select held high, and again with it held low. It toggles the select on every cycle while the accumulator runs and wraps. The bench keeps its own accumulator history and a trigonometric reference, and compares every output word on each cycle. The first cycle that shows the new word must be the fourth after the commit in both modes.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Address decode values; the commit-on-high ordering depends on these.
  localparam int unsigned NCO_ADR_LO = 0;
  localparam int unsigned NCO_ADR_HI = 1;

  // Quadrant of the folded phase, from the top two phase bits.
  typedef enum logic [1:0] {
    QD_RISE_POS = 2'd0,
    QD_FALL_POS = 2'd1,
    QD_FALL_NEG = 2'd2,
    QD_RISE_NEG = 2'd3
  } quad_t;

  localparam real NCO_PI = 3.14159265358979323846;

endpackage

// File: rtl/nco_host_regs.sv
module nco_host_regs #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     lo_word,
  output logic [2*DATA_W-1:0]   freq_word
);
  import nco_pkg::*;

  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(NCO_ADR_LO);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(NCO_ADR_HI);

  logic                hit;
  logic                lo_ld;
  logic                hi_ld;
  logic [DATA_W-1:0]   lo_q, lo_d;
  logic [2*DATA_W-1:0] fw_q, fw_d;

  always_comb begin
    hit   = ~cs_n & wr_en;
    lo_ld = hit && (addr == A_LO);
    hi_ld = hit && (addr == A_HI);
    lo_d  = lo_ld ? wdata : lo_q;
    fw_d  = hi_ld ? {wdata, lo_q} : fw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      fw_q <= '0;
    end else begin
      if (lo_ld) lo_q <= lo_d;
      if (hi_ld) fw_q <= fw_d;
    end
  end

  assign lo_word   = lo_q;
  assign freq_word = fw_q;

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] phase
);
  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb acc_d = acc_q + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign phase = acc_q;

endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
  parameter int IDX_W = 8,
  parameter int OUT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W+1:0]   ph_top,
  output logic [OUT_W-1:0]   sin_val,
  output logic [OUT_W-1:0]   cos_val
);
  import nco_pkg::*;

  localparam int TBL_N = 1 << IDX_W;
  localparam int MAG_W = OUT_W - 1;
  localparam real AMP  = real'((1 << MAG_W) - 1);
  localparam real STEPS = real'(TBL_N * 4);

  function automatic logic [MAG_W-1:0] tbl_val(input int k);
    real ang;
    ang = (2.0 * real'(k) + 1.0) * NCO_PI / STEPS;
    return MAG_W'($rtoi(AMP * $sin(ang) + 0.5));
  endfunction

  logic [MAG_W-1:0] rom [TBL_N];

  for (genvar k = 0; k < TBL_N; k++) begin : g_rom
    localparam logic [MAG_W-1:0] VAL = tbl_val(k);
    assign rom[k] = VAL;
  end

  // Stage 1: fold quadrant into table index and sign
  quad_t            quad;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] s_idx_d, c_idx_d, s_idx_q, c_idx_q;
  logic             s_neg_d, c_neg_d, s_neg_q, c_neg_q;

  always_comb begin
    quad = quad_t'(ph_top[IDX_W+1:IDX_W]);
    idx  = ph_top[IDX_W-1:0];
    unique case (quad)
      QD_RISE_POS: begin s_idx_d = idx;  s_neg_d = 1'b0; c_idx_d = ~idx; c_neg_d = 1'b0; end
      QD_FALL_POS: begin s_idx_d = ~idx; s_neg_d = 1'b0; c_idx_d = idx;  c_neg_d = 1'b1; end
      QD_FALL_NEG: begin s_idx_d = idx;  s_neg_d = 1'b1; c_idx_d = ~idx; c_neg_d = 1'b1; end
      default:     begin s_idx_d = ~idx; s_neg_d = 1'b1; c_idx_d = idx;  c_neg_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_idx_q <= '0; c_idx_q <= '0; s_neg_q <= 1'b0; c_neg_q <= 1'b0;
    end else begin
      s_idx_q <= s_idx_d; c_idx_q <= c_idx_d; s_neg_q <= s_neg_d; c_neg_q <= c_neg_d;
    end
  end

  // Stage 2: table lookup
  logic [MAG_W-1:0] s_mag_d, c_mag_d, s_mag_q, c_mag_q;
  logic             s_sgn_q, c_sgn_q;

  always_comb begin
    s_mag_d = rom[s_idx_q];
    c_mag_d = rom[c_idx_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_mag_q <= '0; c_mag_q <= '0; s_sgn_q <= 1'b0; c_sgn_q <= 1'b0;
    end else begin
      s_mag_q <= s_mag_d; c_mag_q <= c_mag_d; s_sgn_q <= s_neg_q; c_sgn_q <= c_neg_q;
    end
  end

  // Sign application feeds the output register in the top
  logic [OUT_W-1:0] s_ext, c_ext;
  always_comb begin
    s_ext   = {1'b0, s_mag_q};
    c_ext   = {1'b0, c_mag_q};
    sin_val = s_sgn_q ? (~s_ext + OUT_W'(1)) : s_ext;
    cos_val = c_sgn_q ? (~c_ext + OUT_W'(1)) : c_ext;
  end

endmodule

// File: rtl/nco_phase_tap.sv
module nco_phase_tap #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              test_sel,
  output logic [DATA_W-1:0] cos_out,
  output logic [DATA_W-1:0] sin_out
);
  localparam int ACC_W = 2 * DATA_W;
  localparam int TOP_W = IDX_W + 2;

  logic [DATA_W-1:0] lo_word;
  logic [ACC_W-1:0]  freq_word;
  logic [ACC_W-1:0]  acc_q;
  logic [DATA_W-1:0] sin_val, cos_val;

  nco_host_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .lo_word(lo_word), .freq_word(freq_word)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(freq_word), .phase(acc_q)
  );

  nco_sincos #(.IDX_W(IDX_W), .OUT_W(DATA_W)) u_sc (
    .clk(clk), .rst_n(rst_n), .ph_top(acc_q[ACC_W-1 -: TOP_W]),
    .sin_val(sin_val), .cos_val(cos_val)
  );

  // Phase delay matched to the two generator stages
  logic [ACC_W-1:0] ph_d1_q, ph_d2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_d1_q <= '0;
      ph_d2_q <= '0;
    end else begin
      ph_d1_q <= acc_q;
      ph_d2_q <= ph_d1_q;
    end
  end

  // Output register with synchronous source select
  logic [ACC_W-1:0] out_d, out_q;
  always_comb out_d = test_sel ? ph_d2_q : {cos_val, sin_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign cos_out = out_q[ACC_W-1:DATA_W];
  assign sin_out = out_q[DATA_W-1:0];

endmodule

// File: rtl/nco_phase_tap_chk.sv
module nco_phase_tap_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wdata,
  input logic                test_sel,
  input logic [DATA_W-1:0]   cos_out,
  input logic [DATA_W-1:0]   sin_out,
  input logic [DATA_W-1:0]   lo_q,
  input logic [2*DATA_W-1:0] freq_q,
  input logic [2*DATA_W-1:0] acc_q
);
  logic [1:0] fill_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              fill_q <= '0;
    else if (fill_q != 2'd3) fill_q <= fill_q + 2'd1;
  end

  // R1: reset holds outputs at zero
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (cos_out == '0 && sin_out == '0));

  // R2: high-half write commits the staged low half with the data
  p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && wr_en && addr == ADDR_W'(1)) |=> freq_q == {$past(wdata), $past(lo_q)});

  // R3: low-half write alone leaves the tuning word
  p_lo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && wr_en && addr == ADDR_W'(0)) |=> $stable(freq_q));

  // R4: non-writes and unused addresses touch nothing
  p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !wr_en || addr > ADDR_W'(1)) |=> ($stable(freq_q) && $stable(lo_q)));

  // R5: accumulator steps by the committed word
  p_acc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> acc_q == $past(acc_q + freq_q));

  // R6: phase readout carries the three-edge-old accumulator
  p_phase_tap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == 2'd3 && test_sel) |=> {cos_out, sin_out} == $past(acc_q, 3));

endmodule

bind nco_phase_tap nco_phase_tap_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .test_sel(test_sel), .cos_out(cos_out), .sin_out(sin_out),
  .lo_q(lo_word), .freq_q(freq_word), .acc_q(acc_q)
);

// File: tb/nco_phase_tap_bench.sv
module nco_phase_tap_bench;
  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        test_sel = 1'b0;
  logic [15:0] cos_out, sin_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  nco_phase_tap u_nco_phase_tap (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .test_sel(test_sel), .cos_out(cos_out), .sin_out(sin_out)
  );

  // Reference sinusoid from the R7 formula
  function automatic logic [31:0] ref_sc(input logic [9:0] p);
    real a, s, c;
    int ms, mc;
    logic [15:0] so, co;
    a  = (2.0 * real'(p) + 1.0) * PI / 1024.0;
    s  = $sin(a);
    c  = $cos(a);
    ms = $rtoi(32767.0 * (s < 0.0 ? -s : s) + 0.5);
    mc = $rtoi(32767.0 * (c < 0.0 ? -c : c) + 0.5);
    so = (s < 0.0) ? 16'(-ms) : 16'(ms);
    co = (c < 0.0) ? 16'(-mc) : 16'(mc);
    return {co, so};
  endfunction

  // Reference model built from R2..R8
  logic [15:0] m_lo;
  logic [31:0] m_freq, m_acc, m_h1, m_h2, m_exp;
  logic [1:0]  m_fill;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo <= '0; m_freq <= '0; m_acc <= '0; m_h1 <= '0; m_h2 <= '0;
      m_exp <= '0; m_fill <= '0;
    end else begin
      if (!cs_n && wr_en && addr == 3'd0) m_lo <= wdata;
      if (!cs_n && wr_en && addr == 3'd1) m_freq <= {wdata, m_lo};
      m_acc <= m_acc + m_freq;
      m_h1  <= m_acc;
      m_h2  <= m_h1;
      m_exp <= test_sel ? m_h2 : ref_sc(m_h2[31:22]);
      if (m_fill != 2'd3) m_fill <= m_fill + 2'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmp(input string req);
    if (m_fill == 2'd3) chk(req, {cos_out, sin_out}, m_exp);
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step();
      cmp(req);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    cs_n = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
    step();
    cs_n = 1'b1; wr_en = 1'b0; addr = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    step();
    chk("R1 reset cos/sin", {cos_out, sin_out}, 32'h0);
    rst_n = 1'b1;
  endtask

  // R1: outputs zero in reset and phase stays zero with no word loaded
  task automatic t_reset();
    test_sel = 1'b1;
    do_reset();
    for (int i = 0; i < 6; i++) step();
    chk("R1 idle phase", {cos_out, sin_out}, 32'h0);
  endtask

  // R3 then R2: low half alone does nothing; high half commits
  task automatic t_halves();
    logic [31:0] p0;
    test_sel = 1'b1;
    bus_wr(3'd0, 16'hFFFF);
    for (int i = 0; i < 6; i++) step();
    chk("R3 low half only", {cos_out, sin_out}, 32'h0);
    bus_wr(3'd1, 16'h0000);
    run(6, "R2");
    p0 = {cos_out, sin_out};
    step();
    chk("R2 committed step", {cos_out, sin_out} - p0, 32'h0000FFFF);
  endtask

  // R4: ignored writes leave the step size unchanged
  task automatic t_ignored();
    logic [31:0] p0;
    test_sel = 1'b1;
    bus_wr(3'd0, 16'h0123);
    bus_wr(3'd1, 16'h0040);
    cs_n = 1'b1; wr_en = 1'b1; addr = 3'd1; wdata = 16'hAAAA; step();
    cs_n = 1'b0; wr_en = 1'b0; addr = 3'd1; wdata = 16'hBBBB; step();
    for (int a = 2; a < 8; a++) begin
      cs_n = 1'b0; wr_en = 1'b1; addr = 3'(a); wdata = 16'hCCCC; step();
    end
    cs_n = 1'b1; wr_en = 1'b0; addr = '0;
    run(5, "R4");
    p0 = {cos_out, sin_out};
    step();
    chk("R4 step unchanged", {cos_out, sin_out} - p0, 32'h00400123);
  endtask

  // R6: phase readout with an odd word
  task automatic t_phase();
    test_sel = 1'b1;
    bus_wr(3'd0, 16'h5679);
    bus_wr(3'd1, 16'h1234);
    run(30, "R6");
  endtask

  // R5: wrap modulo 2^32
  task automatic t_wrap();
    test_sel = 1'b1;
    bus_wr(3'd0, 16'h0001);
    bus_wr(3'd1, 16'hF000);
    run(40, "R5");
  endtask

  // R7: all 1024 phase points through every quadrant
  task automatic t_quadrants();
    do_reset();
    test_sel = 1'b0;
    bus_wr(3'd0, 16'h0000);
    bus_wr(3'd1, 16'h0040);
    run(1030, "R7");
  endtask

  // R8: alternate source every cycle while running
  task automatic t_interleave();
    bus_wr(3'd0, 16'h3311);
    bus_wr(3'd1, 16'h0A51);
    for (int i = 0; i < 60; i++) begin
      test_sel = i[0];
      step();
      cmp("R8");
    end
  endtask

  // R9: first changed output four edges after commit, both modes
  task automatic t_latency(input logic mode);
    logic [31:0] old_v, new_v;
    do_reset();
    test_sel = mode;
    for (int i = 0; i < 5; i++) step();
    old_v = mode ? 32'h0 : ref_sc(10'd0);
    new_v = mode ? 32'h00400000 : ref_sc(10'd1);
    bus_wr(3'd1, 16'h0040);
    for (int i = 1; i <= 3; i++) begin
      step();
      chk("R9 before new word", {cos_out, sin_out}, old_v);
    end
    step();
    chk("R9 new word at E+4", {cos_out, sin_out}, new_v);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_halves();
    t_ignored();
    t_phase();
    t_wrap();
    t_quadrants();
    t_interleave();
    t_latency(1'b1);
    t_latency(1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule